// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Controller

This block gathers interrupt events from a number of GPIO groups of sixteen pins each. Every pin has a trigger setting, a mask bit and a pending bit. Two groups are packed into each 32-bit register: the even group sits in bits 15:0 and the odd group in bits 31:16. A single combined interrupt line goes high while any pending pin is also unmasked.

Software services the interrupt by reading one read-only service word. That word names the next source to handle as a group code and a pin number. Software then clears that source by writing a one to its pending bit, and the service word moves on to the next source. The group code is the group index plus one, and code 0 means idle. Two 8-pin banks that share group 0 are therefore both reported under code 1: the first bank uses pins 0 to 7, and the second uses pins 8 to 15, which map to its own pins 0 to 7 after subtracting 8.

Pin inputs pass through a two-flop synchroniser before edge or level detection. Pin function selection and pad logic belong elsewhere.

Top module: `gpio_irq_svc`

## Requirements
- R1: After reset, every mask bit is 1. Every trigger field reads 4 (rising edge), so a configuration register reads 0x44444444. Every pending bit is 0, the service word reads 0 and irq_o is low.
- R2: A pin that goes high while set to rising edge shows its pending bit after the third rising clock edge from the change, and not after the second.
- R3: Trigger field codes are 0 low level, 1 high level, 2 falling edge, 4 rising edge and 6 both edges. Bit 3 of a field is not stored and reads 0. The field for bit position p (p = 16·(g mod 2) + pin) lies in configuration register g/2 at bits 4·(p/4)+3 : 4·(p/4), so one field governs four adjacent pins. An edge code ignores the opposite edge.
- R4: In a level mode the pending bit is set on every cycle the level is active. A write-one clear only takes effect once the level has gone inactive.
- R5: A mask bit of 1 keeps its pin out of irq_o and out of the service word. Events still set the pin's pending bit while it is masked.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R7: The service word holds the group index plus 1 in bits 7:4 and the pin number in bits 3:0. Its bits 31:8 read 0, and it reads 0 when nothing unmasked is pending. Pins 0–7 and 8–15 of group 0 both report group code 1.
- R8: With several sources active, the service word names the lowest group first, and within that group the lowest pin.
- R9: irq_o is high exactly when some pending bit is set with its mask bit clear, and it drops once that bit is cleared.
- R10: The service word is read-only. Writing to it changes no register and no output.
- R11: Byte address map: configuration register r at 0x00+4r, mask register r at 0x20+4r, pending register r at 0x40+4r, service word at 0x60. Register r holds group 2r in bits 15:0 and group 2r+1 in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_GROUPS*16 | Raw pin levels, group g pin k at bit 16g+k |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Single rising, falling and both-edge stimuli on pins in separate fields confirm that each trigger code accepts its own edge and rejects the opposite one. A held level checks that a clear is refused while the level is still active. Driving the level-low code on idle pins sets four pending bits together, which shows that one field governs four pins. A masked edge separates the pending state from what irq_o and the service word report. Several simultaneous sources, cleared one at a time, fix the reporting order and the shared group-code-1 numbering of the two 8-pin banks.

// File: rtl/gisc_pkg.sv
package gisc_pkg;
   localparam int GROUP_PINS = 16;
   localparam int FIELD_W    = 4;
   localparam int CODE_W     = 3;
   localparam int REG_W      = 32;

   localparam logic [CODE_W-1:0] TRIG_LOW  = 3'd0;
   localparam logic [CODE_W-1:0] TRIG_HIGH = 3'd1;
   localparam logic [CODE_W-1:0] TRIG_FALL = 3'd2;
   localparam logic [CODE_W-1:0] TRIG_RISE = 3'd4;
   localparam logic [CODE_W-1:0] TRIG_BOTH = 3'd6;

   typedef enum logic [1:0] {
      REG_CFG  = 2'd0,
      REG_MASK = 2'd1,
      REG_PEND = 2'd2,
      REG_SVC  = 2'd3
   } region_e;
endpackage

// File: rtl/gisc_sync.sv
// Two-flop synchroniser plus one history flop for edge detection.
module gisc_sync #(
   parameter int N = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] pins_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] s1_q, s2_q, hist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_q   <= '0;
         s2_q   <= '0;
         hist_q <= '0;
      end else begin
         s1_q   <= pins_i;
         s2_q   <= s1_q;
         hist_q <= s2_q;
      end
   end

   assign lvl_o  = s2_q;
   assign rise_o = s2_q & ~hist_q;
   assign fall_o = ~s2_q & hist_q;
endmodule

// File: rtl/gisc_trigger.sv
// Per-pin event decode; each 3-bit code serves four adjacent pins.
module gisc_trigger import gisc_pkg::*; #(
   parameter int N = 64
) (
   input  logic [(N/FIELD_W)*CODE_W-1:0] cfg_i,
   input  logic [N-1:0]                  lvl_i,
   input  logic [N-1:0]                  rise_i,
   input  logic [N-1:0]                  fall_i,
   output logic [N-1:0]                  evt_o
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic [CODE_W-1:0] code;
      assign code = cfg_i[CODE_W*(i/FIELD_W) +: CODE_W];
      if (1) begin : g_dec
         always_comb begin
            if (code[2:1] == 2'b00)
               evt_o[i] = (lvl_i[i] == code[0]);
            else
               evt_o[i] = (code[2] & rise_i[i]) | (code[1] & fall_i[i]);
         end
      end
   end
endmodule

// File: rtl/gisc_prio.sv
// Lowest-index active source wins.
module gisc_prio #(
   parameter int N     = 64,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     act_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (act_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/gpio_irq_svc.sv
module gpio_irq_svc import gisc_pkg::*; #(
   parameter int NUM_GROUPS = 4,
   parameter int ADDR_W     = 8
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [NUM_GROUPS*GROUP_PINS-1:0] pins_i,
   input  logic [ADDR_W-1:0]                bus_addr_i,
   input  logic                             bus_we_i,
   input  logic [REG_W-1:0]                 bus_wdata_i,
   output logic [REG_W-1:0]                 bus_rdata_o,
   output logic                             irq_o
);
   localparam int N     = NUM_GROUPS * GROUP_PINS;
   localparam int NREG  = NUM_GROUPS / 2;
   localparam int NF    = N / FIELD_W;
   localparam int FPR   = REG_W / FIELD_W;
   localparam int IDX_W = $clog2(N);

   if (NUM_GROUPS < 2 || NUM_GROUPS > 14 || (NUM_GROUPS % 2) != 0) begin : g_bad_groups
      $error("NUM_GROUPS must be even and within 2..14");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must be at least 7");
   end

   logic [NF*CODE_W-1:0] cfg_q;
   logic [N-1:0]         mask_q, pend_q, clr_w, evt_w, act_w;
   logic [N-1:0]         lvl_w, rise_w, fall_w;
   logic                 found_w;
   logic [IDX_W-1:0]     idx_w;
   logic [7:0]           svc_w;

   // Address decode
   region_e   region;
   logic [2:0] ridx;
   logic      addr_ok;
   assign region  = region_e'(bus_addr_i[6:5]);
   assign ridx    = bus_addr_i[4:2];
   assign addr_ok = (bus_addr_i[1:0] == 2'b00) && ((bus_addr_i >> 7) == '0);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic              sel;
      logic [REG_W-1:0]  mask_r;
      logic [FPR*CODE_W-1:0] cfg_r;

      assign sel = addr_ok && bus_we_i && (ridx == 3'(r));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_r <= '1;
            for (int f = 0; f < FPR; f++) cfg_r[CODE_W*f +: CODE_W] <= TRIG_RISE;
         end else begin
            if (sel && region == REG_MASK) mask_r <= bus_wdata_i;
            if (sel && region == REG_CFG)
               for (int f = 0; f < FPR; f++)
                  cfg_r[CODE_W*f +: CODE_W] <= bus_wdata_i[FIELD_W*f +: CODE_W];
         end
      end

      assign mask_q[REG_W*r +: REG_W]           = mask_r;
      assign cfg_q[FPR*CODE_W*r +: FPR*CODE_W]  = cfg_r;
      assign clr_w[REG_W*r +: REG_W]            = (sel && region == REG_PEND) ? bus_wdata_i : '0;
   end

   gisc_sync #(.N(N)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pins_i(pins_i),
      .lvl_o (lvl_w),
      .rise_o(rise_w),
      .fall_o(fall_w)
   );

   gisc_trigger #(.N(N)) u_trig (
      .cfg_i (cfg_q),
      .lvl_i (lvl_w),
      .rise_i(rise_w),
      .fall_i(fall_w),
      .evt_o (evt_w)
   );

   // A new event in the clearing cycle keeps the bit set.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_w) | evt_w;
   end

   assign act_w = pend_q & ~mask_q;

   gisc_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
      .act_i  (act_w),
      .found_o(found_w),
      .idx_o  (idx_w)
   );

   assign svc_w = found_w ? {4'(idx_w >> 4) + 4'd1, idx_w[3:0]} : 8'h00;
   assign irq_o = |act_w;

   always_comb begin
      bus_rdata_o = '0;
      if (addr_ok) begin
         unique case (region)
            REG_CFG:
               for (int r = 0; r < NREG; r++)
                  if (ridx == 3'(r))
                     for (int f = 0; f < FPR; f++)
                        bus_rdata_o[FIELD_W*f +: CODE_W] = cfg_q[CODE_W*(FPR*r+f) +: CODE_W];
            REG_MASK:
               for (int r = 0; r < NREG; r++)
                  if (ridx == 3'(r)) bus_rdata_o = mask_q[REG_W*r +: REG_W];
            REG_PEND:
               for (int r = 0; r < NREG; r++)
                  if (ridx == 3'(r)) bus_rdata_o = pend_q[REG_W*r +: REG_W];
            REG_SVC:
               if (ridx == 3'd0) bus_rdata_o = {24'h0, svc_w};
            default: bus_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_irq_svc_chk.sv
module gpio_irq_svc_chk #(
   parameter int NUM_GROUPS = 4,
   parameter int ADDR_W     = 8
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       irq_o,
   input logic [7:0]                 svc_w,
   input logic [NUM_GROUPS*16-1:0]   pend_q,
   input logic [NUM_GROUPS*16-1:0]   mask_q,
   input logic [NUM_GROUPS*16-1:0]   evt_w,
   input logic                       bus_we_i,
   input logic [ADDR_W-1:0]          bus_addr_i,
   input logic [31:0]                bus_wdata_i
);
   localparam int N     = NUM_GROUPS * 16;
   localparam int IDX_W = $clog2(N);

   logic [N-1:0]     act;
   logic [IDX_W-1:0] idx_c;
   assign act   = pend_q & ~mask_q;
   assign idx_c = IDX_W'({svc_w[7:4] - 4'd1, svc_w[3:0]});

   // R9: combined line agrees with the service word
   a_r9_irq_matches_svc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (svc_w[7:4] != 4'd0));

   // R7: a reported source is pending and unmasked
   a_r7_svc_points_at_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> act[idx_c]);

   // R8: reported source is the lowest active bit
   a_r8_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act != '0) |-> ((act & (~act + N'(1))) == (N'(1) << idx_c)));

   // R6: a write-one clear to pending register 0 takes effect unless an event arrives
   a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(8'h40)) |=>
      ((pend_q[31:0] & $past(bus_wdata_i) & ~$past(evt_w[31:0])) == 32'h0));

   // R2: a pending bit only rises after an event
   a_r2_pend_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q & ~$past(pend_q) & ~$past(evt_w)) == '0);
endmodule

bind gpio_irq_svc gpio_irq_svc_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .irq_o      (irq_o),
   .svc_w      (svc_w),
   .pend_q     (pend_q),
   .mask_q     (mask_q),
   .evt_w      (evt_w),
   .bus_we_i   (bus_we_i),
   .bus_addr_i (bus_addr_i),
   .bus_wdata_i(bus_wdata_i)
);

// File: tb/gpio_irq_svc_bench.sv
module gpio_irq_svc_bench;
   localparam int NG = 4;
   localparam int N  = NG * 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic [7:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_svc #(.NUM_GROUPS(NG), .ADDR_W(8)) u_gpio_irq_svc (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
      .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic pin_set(input int i, input logic v);
      pins[i] = v;
      wait_n(3);
   endtask

   task automatic t_reset;
      chk_reg("R1 cfg0", 8'h00, 32'h4444_4444);
      chk_reg("R1 cfg1", 8'h04, 32'h4444_4444);
      chk_reg("R1 mask0", 8'h20, 32'hFFFF_FFFF);
      chk_reg("R11 mask1", 8'h24, 32'hFFFF_FFFF);
      chk_reg("R1 pend0", 8'h40, 32'h0);
      chk_reg("R1 svc", 8'h60, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_rising;
      wr(8'h20, 32'h0);
      wr(8'h24, 32'h0);
      chk_reg("R11 mask0 write", 8'h20, 32'h0);
      pins[3] = 1'b1;
      wait_n(2);
      chk_reg("R2 not yet pending", 8'h40, 32'h0);
      wait_n(1);
      chk_reg("R2 pending", 8'h40, 32'h0000_0008);
      check("R9 irq high", {31'h0, irq}, 32'h1);
      chk_reg("R7 svc first bank", 8'h60, 32'h13);
      wr(8'h40, 32'h0);
      chk_reg("R6 zero write keeps", 8'h40, 32'h0000_0008);
      wr(8'h40, 32'h0000_0008);
      chk_reg("R6 clear", 8'h40, 32'h0);
      check("R9 irq low", {31'h0, irq}, 32'h0);
      pin_set(3, 1'b0);
      chk_reg("R3 rising ignores fall", 8'h40, 32'h0);
      pin_set(9, 1'b1);
      chk_reg("R7 svc second bank", 8'h60, 32'h19);
      wr(8'h40, 32'h0000_0200);
      pin_set(9, 1'b0);
   endtask

   task automatic t_falling;
      wr(8'h00, 32'h4424_4444);
      pin_set(21, 1'b1);
      chk_reg("R3 falling ignores rise", 8'h40, 32'h0);
      pin_set(21, 1'b0);
      chk_reg("R3 falling", 8'h40, 32'h0020_0000);
      chk_reg("R7 svc group1", 8'h60, 32'h25);
      wr(8'h40, 32'h0020_0000);
      wr(8'h00, 32'h4444_4444);
   endtask

   task automatic t_both;
      wr(8'h00, 32'hE444_4444);
      chk_reg("R3 bit3 not stored", 8'h00, 32'h6444_4444);
      pin_set(30, 1'b1);
      chk_reg("R3 both rise", 8'h40, 32'h4000_0000);
      chk_reg("R7 svc 0x2E", 8'h60, 32'h2E);
      wr(8'h40, 32'h4000_0000);
      pin_set(30, 1'b0);
      chk_reg("R3 both fall", 8'h40, 32'h4000_0000);
      wr(8'h40, 32'h4000_0000);
      wr(8'h00, 32'h4444_4444);
   endtask

   task automatic t_level;
      wr(8'h04, 32'h4444_4441);
      pin_set(33, 1'b1);
      chk_reg("R4 level high", 8'h44, 32'h0000_0002);
      chk_reg("R7 svc group2", 8'h60, 32'h31);
      wr(8'h44, 32'h0000_0002);
      chk_reg("R4 clear refused", 8'h44, 32'h0000_0002);
      pin_set(33, 1'b0);
      wr(8'h44, 32'h0000_0002);
      chk_reg("R4 clear after low", 8'h44, 32'h0);
      wr(8'h04, 32'h4444_4044);
      wait_n(2);
      chk_reg("R3 low level four pins", 8'h44, 32'h0000_0F00);
      wr(8'h04, 32'h4444_4444);
      wr(8'h44, 32'h0000_0F00);
      chk_reg("R6 clear group", 8'h44, 32'h0);
   endtask

   task automatic t_mask;
      wr(8'h24, 32'h0001_0000);
      pin_set(48, 1'b1);
      chk_reg("R5 masked still pends", 8'h44, 32'h0001_0000);
      check("R5 masked irq", {31'h0, irq}, 32'h0);
      chk_reg("R5 masked svc", 8'h60, 32'h0);
      wr(8'h24, 32'h0);
      check("R5 unmask irq", {31'h0, irq}, 32'h1);
      chk_reg("R7 svc group3", 8'h60, 32'h40);
      wr(8'h44, 32'h0001_0000);
      pin_set(48, 1'b0);
   endtask

   task automatic t_prio;
      pins[48] = 1'b1; pins[25] = 1'b1; pins[18] = 1'b1;
      wait_n(3);
      chk_reg("R8 lowest pin first", 8'h60, 32'h22);
      wr(8'h40, 32'h0004_0000);
      chk_reg("R8 next pin", 8'h60, 32'h29);
      wr(8'h40, 32'h0200_0000);
      chk_reg("R8 next group", 8'h60, 32'h40);
      wr(8'h44, 32'h0001_0000);
      chk_reg("R8 drained", 8'h60, 32'h0);
      check("R9 irq drained", {31'h0, irq}, 32'h0);
      pins[48] = 1'b0; pins[25] = 1'b0; pins[18] = 1'b0;
      wait_n(3);
   endtask

   task automatic t_svc_ro;
      wr(8'h60, 32'hFFFF_FFFF);
      chk_reg("R10 svc unchanged", 8'h60, 32'h0);
      chk_reg("R10 pend0 unchanged", 8'h40, 32'h0);
      chk_reg("R10 mask0 unchanged", 8'h20, 32'h0);
      chk_reg("R10 cfg0 unchanged", 8'h00, 32'h4444_4444);
      check("R10 irq", {31'h0, irq}, 32'h0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset;
      t_rising;
      t_falling;
      t_both;
      t_level;
      t_mask;
      t_prio;
      t_svc_ro;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule